// File: doc/BRIEF.md
# Hybrid Protected Scratchpad Controller

A word-addressed data scratchpad behind a single request/response port. The address space is split into three regions, each with its own storage style. A fast region keeps one parity bit per word. A corrected region keeps seven SEC-DED check bits per word. A non-volatile region keeps bare words: it is treated as immune to upsets, reads quickly and writes slowly. Every request is decoded to a region, check bits are generated on writes, and reads are checked or corrected, with a status code returned alongside the data.

Only one request is in flight at a time. The latency of each access is fixed by its region and direction. `req_ready` stays low while a multi-cycle access is running. A test port XORs masks into a stored word and its check bits, so that upsets can be provoked without disturbing timing. A saturating counter tracks completed writes to the non-volatile region and raises an alarm once it reaches a limit supplied at a port.

Top module: `hps_scratchpad`

## Requirements
- R1: With the default sizes, byte addresses 0x0000–0x07FF select the parity region, 0x0800–0x0FFF the SEC-DED region and 0x1000–0x3FFF the non-volatile region. In general each region's base follows the word count of the region before it. Bits [1:0] of the address must be zero.
- R2: A parity-region read or write produces its one-cycle `rsp_valid` pulse at the first rising edge after the request is presented, counting the accepting edge. A read returns the last value written.
- R3: A SEC-DED-region read or write responds at the second rising edge, counting the accepting edge as the first.
- R4: A non-volatile read responds at the first edge, and a non-volatile write responds at the tenth edge.
- R5: `req_ready` is low from the edge that accepts a multi-cycle request until the edge that presents its response. No response is presented while `req_ready` is low.
- R6: `rsp_status` encodes 0 = clean, 1 = corrected, 2 = uncorrectable, 3 = address error. In the parity region, an odd number of flipped bits returns status 2 with the stored data as found. An even number of flipped bits returns status 0 with the flipped data.
- R7: In the SEC-DED region, a single flipped bit, whether in the data or in a check bit, returns the original data with status 1. Two flipped data bits return status 2.
- R8: The non-volatile region never reports status 1 or 2. A flipped stored bit comes back as flipped data with status 0.
- R9: A misaligned or out-of-range address responds at the first edge with status 3 and zero data, and it writes nothing. Write responses carry zero data.
- R10: A corrected read does not repair the stored word. Repeated reads keep returning status 1 until the word is written again, after which status is 0.
- R11: `wear_count` counts completed non-volatile writes, saturates at all ones and never wraps. `wear_alarm` is high whenever `wear_count` is at or above `wear_limit`.
- R12: After reset, `rsp_valid` is 0, `req_ready` is 1 and `wear_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and address errors |
| rsp_status | output | 2 | Clean, corrected, uncorrectable or address error |
| inj_en | input | 1 | Test port: apply the masks this cycle |
| inj_addr | input | AW | Test port: byte address of the target word |
| inj_data_mask | input | 32 | Test port: XOR mask for the stored data |
| inj_chk_mask | input | 7 | Test port: XOR mask for the stored check bits (bit 0 is the parity bit) |
| wear_limit | input | WEAR_W | Alarm threshold for non-volatile writes |
| wear_count | output | WEAR_W | Saturating count of completed non-volatile writes |
| wear_alarm | output | 1 | Count at or above the threshold |

## Verification
The bench shrinks the regions to 8, 8 and 16 words and narrows the wear counter to 3 bits. With those values the first and last word of every region, the first illegal address past the end, and counter saturation at 7 are all reached within a few dozen requests. The latencies keep their default values, so the 1, 2 and 10 cycle slots and the stall of `req_ready` are measured exactly as the full-size block would show them.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int CW_W   = 39;

  typedef enum logic [1:0] {RGN_PAR, RGN_ECC, RGN_NV, RGN_BAD} region_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_CORR = 2'd1, ST_UNCORR = 2'd2, ST_ADDR = 2'd3} status_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    status_e           status;
  } rd_result_t;

  // Hamming layout: check bit i at position 2**i, overall parity at position 0.
  function automatic logic [CW_W-1:0] ecc_place(input logic [DATA_W-1:0] d, input logic [CHK_W-1:0] c);
    logic [CW_W-1:0] cw;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 6; i++) cw[1 << i] = c[i];
    cw[0] = c[6];
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(input logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [5:0] ecc_syndrome(input logic [CW_W-1:0] cw);
    logic [5:0] s;
    s = '0;
    for (int i = 0; i < 6; i++)
      for (int p = 1; p < CW_W; p++)
        if (((p >> i) & 1) == 1) s[i] = s[i] ^ cw[p];
    return s;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [5:0] s;
    s = ecc_syndrome(ecc_place(d, '0));
    return {^ecc_place(d, {1'b0, s}), s};
  endfunction

  function automatic rd_result_t ecc_check(input logic [DATA_W-1:0] d, input logic [CHK_W-1:0] c);
    logic [CW_W-1:0] cw;
    logic [5:0] s;
    rd_result_t r;
    cw = ecc_place(d, c);
    s = ecc_syndrome(cw);
    r.status = ST_OK;
    if (^cw) begin
      if (s < 6'(CW_W)) begin
        if (s != 0) cw[s] = ~cw[s];
        r.status = ST_CORR;
      end else begin
        r.status = ST_UNCORR;
      end
    end else if (s != 0) begin
      r.status = ST_UNCORR;
    end
    r.data = ecc_extract(cw);
    return r;
  endfunction

  function automatic rd_result_t par_check(input logic [DATA_W-1:0] d, input logic p);
    rd_result_t r;
    r.data = d;
    r.status = (^{d, p}) ? ST_UNCORR : ST_OK;
    return r;
  endfunction
endpackage

// File: rtl/hps_decode.sv
module hps_decode
  import hps_pkg::*;
#(
  parameter int AW        = 14,
  parameter int PAR_WORDS = 512,
  parameter int ECC_WORDS = 512,
  parameter int NV_WORDS  = 3072,
  parameter int IW        = 12
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [IW-1:0] idx
);
  localparam logic [31:0] ECC_BASE = 32'(PAR_WORDS);
  localparam logic [31:0] NV_BASE  = 32'(PAR_WORDS + ECC_WORDS);
  localparam logic [31:0] TOP      = 32'(PAR_WORDS + ECC_WORDS + NV_WORDS);

  logic [31:0] word;
  assign word = 32'(addr[AW-1:2]);

  always_comb begin
    region = RGN_BAD;
    idx    = '0;
    if (addr[1:0] == 2'b00) begin
      if (word < ECC_BASE) begin
        region = RGN_PAR;
        idx    = IW'(word);
      end else if (word < NV_BASE) begin
        region = RGN_ECC;
        idx    = IW'(word - ECC_BASE);
      end else if (word < TOP) begin
        region = RGN_NV;
        idx    = IW'(word - NV_BASE);
      end
    end
  end
endmodule

// File: rtl/hps_wear.sv
module hps_wear #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         alarm
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc && count != CMAX) count <= count + 1'b1;
  end

  assign alarm = (count >= limit);

  p_wear_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc && count != CMAX |=> count == $past(count) + 1'b1);
  p_wear_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count == CMAX |=> count == CMAX);
  p_wear_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/hps_scratchpad.sv
module hps_scratchpad
  import hps_pkg::*;
#(
  parameter int AW        = 14,
  parameter int PAR_WORDS = 512,
  parameter int ECC_WORDS = 512,
  parameter int NV_WORDS  = 3072,
  parameter int PAR_LAT   = 1,
  parameter int ECC_LAT   = 2,
  parameter int NV_RD_LAT = 1,
  parameter int NV_WR_LAT = 10,
  parameter int WEAR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_status,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [31:0]       inj_data_mask,
  input  logic [6:0]        inj_chk_mask,
  input  logic [WEAR_W-1:0] wear_limit,
  output logic [WEAR_W-1:0] wear_count,
  output logic              wear_alarm
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXW = max2(max2(PAR_WORDS, ECC_WORDS), NV_WORDS);
  localparam int IW   = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam int MAXL = max2(max2(PAR_LAT, ECC_LAT), max2(NV_RD_LAT, NV_WR_LAT));
  localparam int LW   = $clog2(MAXL + 1);

  logic [32:0] par_mem [PAR_WORDS];
  logic [38:0] ecc_mem [ECC_WORDS];
  logic [31:0] nv_mem  [NV_WORDS];

  region_e rq_region, inj_region, q_region, op_region, rsp_region_q;
  logic [IW-1:0] rq_idx, inj_idx, q_idx, op_idx;
  logic q_write, op_write, busy, accept, fin, wear_inc;
  logic [31:0] q_wdata, op_wdata;
  logic [LW-1:0] cnt, rq_lat;
  rd_result_t res;

  hps_decode #(.AW(AW), .PAR_WORDS(PAR_WORDS), .ECC_WORDS(ECC_WORDS), .NV_WORDS(NV_WORDS), .IW(IW))
    u_req_dec (.addr(req_addr), .region(rq_region), .idx(rq_idx));
  hps_decode #(.AW(AW), .PAR_WORDS(PAR_WORDS), .ECC_WORDS(ECC_WORDS), .NV_WORDS(NV_WORDS), .IW(IW))
    u_inj_dec (.addr(inj_addr), .region(inj_region), .idx(inj_idx));

  always_comb begin
    unique case (rq_region)
      RGN_PAR: rq_lat = LW'(PAR_LAT);
      RGN_ECC: rq_lat = LW'(ECC_LAT);
      RGN_NV:  rq_lat = req_write ? LW'(NV_WR_LAT) : LW'(NV_RD_LAT);
      default: rq_lat = LW'(1);
    endcase
  end

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign fin       = (accept && rq_lat == LW'(1)) || (busy && cnt == '0);
  assign op_region = busy ? q_region : rq_region;
  assign op_idx    = busy ? q_idx    : rq_idx;
  assign op_write  = busy ? q_write  : req_write;
  assign op_wdata  = busy ? q_wdata  : req_wdata;
  assign wear_inc  = fin && op_write && op_region == RGN_NV;

  // Sequencer: latches a multi-cycle request and counts down its slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      q_region <= RGN_BAD;
      q_idx <= '0;
      q_write <= 1'b0;
      q_wdata <= '0;
    end else if (accept && rq_lat > LW'(1)) begin
      busy <= 1'b1;
      cnt <= rq_lat - LW'(2);
      q_region <= rq_region;
      q_idx <= rq_idx;
      q_write <= req_write;
      q_wdata <= req_wdata;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  // Storage: injection first, a completing write to the same word wins.
  always_ff @(posedge clk) begin
    if (inj_en) begin
      case (inj_region)
        RGN_PAR: par_mem[inj_idx] <= par_mem[inj_idx] ^ {inj_chk_mask[0], inj_data_mask};
        RGN_ECC: ecc_mem[inj_idx] <= ecc_mem[inj_idx] ^ {inj_chk_mask, inj_data_mask};
        RGN_NV:  nv_mem[inj_idx]  <= nv_mem[inj_idx] ^ inj_data_mask;
        default: ;
      endcase
    end
    if (fin && op_write) begin
      case (op_region)
        RGN_PAR: par_mem[op_idx] <= {^op_wdata, op_wdata};
        RGN_ECC: ecc_mem[op_idx] <= {ecc_encode(op_wdata), op_wdata};
        RGN_NV:  nv_mem[op_idx]  <= op_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (op_region)
      RGN_PAR: res = par_check(par_mem[op_idx][31:0], par_mem[op_idx][32]);
      RGN_ECC: res = ecc_check(ecc_mem[op_idx][31:0], ecc_mem[op_idx][38:32]);
      RGN_NV:  res = '{data: nv_mem[op_idx], status: ST_OK};
      default: res = '{data: '0, status: ST_ADDR};
    endcase
    if (op_write && op_region != RGN_BAD) res = '{data: '0, status: ST_OK};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_status <= ST_OK;
      rsp_region_q <= RGN_BAD;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        rsp_rdata <= res.data;
        rsp_status <= res.status;
        rsp_region_q <= op_region;
      end
    end
  end

  hps_wear #(.W(WEAR_W)) u_wear (
    .clk(clk), .rst_n(rst_n), .inc(wear_inc), .limit(wear_limit),
    .count(wear_count), .alarm(wear_alarm)
  );

  p_par_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (PAR_LAT == 1) && accept && rq_region == RGN_PAR |=> rsp_valid && rsp_status != ST_CORR);
  p_ecc_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ECC_LAT == 2) && accept && rq_region == RGN_ECC |=> !rsp_valid ##1 rsp_valid);
  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rsp_valid);
  p_nv_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region_q == RGN_NV |-> rsp_status == ST_OK);
  p_bad_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rq_region == RGN_BAD |=> rsp_valid && rsp_status == ST_ADDR && rsp_rdata == '0);
endmodule

// File: tb/tb_hps_scratchpad.sv
module tb_hps_scratchpad;
  localparam int CLK_PERIOD = 10;
  localparam int WEAR_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, inj_en = 0;
  logic [13:0] req_addr = '0, inj_addr = '0;
  logic [31:0] req_wdata = '0, inj_data_mask = '0;
  logic [6:0] inj_chk_mask = '0;
  logic [WEAR_W-1:0] wear_limit = 3'd3;
  logic req_ready, rsp_valid, wear_alarm;
  logic [31:0] rsp_rdata;
  logic [1:0] rsp_status;
  logic [WEAR_W-1:0] wear_count;

  hps_scratchpad #(.AW(14), .PAR_WORDS(8), .ECC_WORDS(8), .NV_WORDS(16), .WEAR_W(WEAR_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_data_mask(inj_data_mask),
    .inj_chk_mask(inj_chk_mask), .wear_limit(wear_limit), .wear_count(wear_count),
    .wear_alarm(wear_alarm));

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [31:0] data;
    logic [1:0]  st;
    int          lat;
    int          acc;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the oldest expectation whenever a response appears.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "unexpected response", rsp_rdata, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
        check(rsp_status == e.st, {e.tag, " status"}, rsp_status, e.st);
        check(cyc - e.acc == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
      end
    end
  end

  task automatic do_req(input logic w, input logic [13:0] a, input logic [31:0] wd,
                        input logic [31:0] ed, input logic [1:0] es, input int el, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = wd;
    e.data = ed; e.st = es; e.lat = el; e.acc = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 0;
    if (el > 1) check(req_ready == 0, {tag, " R5 ready low while busy"}, req_ready, 0);
  endtask

  task automatic drain();
    while (sb.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic inject(input logic [13:0] a, input logic [31:0] dm, input logic [6:0] cm);
    drain();
    inj_en = 1; inj_addr = a; inj_data_mask = dm; inj_chk_mask = cm;
    @(negedge clk);
    inj_en = 0; inj_data_mask = '0; inj_chk_mask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(rsp_valid == 0, "R12 rsp_valid", rsp_valid, 0);
    check(req_ready == 1, "R12 ready", req_ready, 1);
    check(wear_count == 0, "R12 wear_count", wear_count, 0);
    rst_n = 1;

    // R2 parity region, R1 edges
    do_req(1, 14'h004, 32'hA5A5_0001, 0, 0, 1, "R2 par write");
    do_req(0, 14'h004, 0, 32'hA5A5_0001, 0, 1, "R2 par read");
    do_req(1, 14'h01C, 32'h1111_0007, 0, 0, 1, "R1 par last write");
    do_req(0, 14'h01C, 0, 32'h1111_0007, 0, 1, "R1 par last read");
    // R3 SEC-DED region
    do_req(1, 14'h020, 32'h2222_0000, 0, 0, 2, "R1 ecc first write");
    do_req(0, 14'h020, 0, 32'h2222_0000, 0, 2, "R1 ecc first read");
    do_req(1, 14'h024, 32'h1234_5678, 0, 0, 2, "R3 ecc write");
    do_req(0, 14'h024, 0, 32'h1234_5678, 0, 2, "R3 ecc read");
    // R4 non-volatile region
    do_req(1, 14'h044, 32'hCAFE_F00D, 0, 0, 10, "R4 nv write");
    do_req(0, 14'h044, 0, 32'hCAFE_F00D, 0, 1, "R4 nv read");
    do_req(0, 14'h01C, 0, 32'h1111_0007, 0, 1, "R1 par last unaffected");
    drain();
    check(wear_count == 1, "R11 count after one", wear_count, 1);
    check(wear_alarm == 0, "R11 alarm below limit", wear_alarm, 0);

    // R6 parity: odd and even flips
    inject(14'h004, 32'h0000_0010, 7'h0);
    do_req(0, 14'h004, 0, 32'hA5A5_0011, 2, 1, "R6 par single flip");
    do_req(1, 14'h008, 32'h0F0F_0F0F, 0, 0, 1, "R6 par write");
    inject(14'h008, 32'h0000_0300, 7'h0);
    do_req(0, 14'h008, 0, 32'h0F0F_0C0F, 0, 1, "R6 par even flips silent");
    do_req(1, 14'h00C, 32'h0000_0055, 0, 0, 1, "R6 par write2");
    inject(14'h00C, 32'h0, 7'h1);
    do_req(0, 14'h00C, 0, 32'h0000_0055, 2, 1, "R6 par check-bit flip");

    // R7 / R10 SEC-DED correction, no scrub
    inject(14'h024, 32'h0000_0080, 7'h0);
    do_req(0, 14'h024, 0, 32'h1234_5678, 1, 2, "R7 ecc single data flip");
    do_req(0, 14'h024, 0, 32'h1234_5678, 1, 2, "R10 corrected status persists");
    do_req(1, 14'h024, 32'h1234_5678, 0, 0, 2, "R10 rewrite");
    do_req(0, 14'h024, 0, 32'h1234_5678, 0, 2, "R10 clean after rewrite");
    do_req(1, 14'h028, 32'hDEAD_BEEF, 0, 0, 2, "R7 ecc write");
    inject(14'h028, 32'h0, 7'h04);
    do_req(0, 14'h028, 0, 32'hDEAD_BEEF, 1, 2, "R7 ecc check-bit flip");
    inject(14'h028, 32'h0, 7'h44);
    do_req(0, 14'h028, 0, 32'hDEAD_BEEF, 1, 2, "R7 ecc overall-bit flip");
    do_req(1, 14'h03C, 32'h0BAD_C0DE, 0, 0, 2, "R7 ecc last write");
    inject(14'h03C, 32'h0000_0011, 7'h0);
    do_req(0, 14'h03C, 0, 32'h0BAD_C0DE ^ 32'h11, 2, 2, "R7 ecc double flip");

    // R8 non-volatile: flips pass through clean
    inject(14'h044, 32'h0000_00FF, 7'h7F);
    do_req(0, 14'h044, 0, 32'hCAFE_F0F2, 0, 1, "R8 nv flip no flag");

    // R9 address errors
    do_req(0, 14'h080, 0, 0, 3, 1, "R9 out-of-range read");
    do_req(0, 14'h006, 0, 0, 3, 1, "R9 misaligned read");
    do_req(1, 14'h000, 32'h7777_7777, 0, 0, 1, "R9 par base write");
    do_req(1, 14'h002, 32'h9999_9999, 0, 3, 1, "R9 misaligned write");
    do_req(1, 14'h3FFC, 32'h9999_9999, 0, 3, 1, "R9 high write");
    do_req(0, 14'h000, 0, 32'h7777_7777, 0, 1, "R9 storage untouched");

    // R11 wear counter threshold and saturation, R1 nv edges
    do_req(1, 14'h040, 32'h4040_4040, 0, 0, 10, "R1 nv first write");
    do_req(1, 14'h07C, 32'h7C7C_7C7C, 0, 0, 10, "R1 nv last write");
    drain();
    check(wear_count == 3, "R11 count at limit", wear_count, 3);
    check(wear_alarm == 1, "R11 alarm at limit", wear_alarm, 1);
    do_req(0, 14'h040, 0, 32'h4040_4040, 0, 1, "R1 nv first read");
    do_req(0, 14'h07C, 0, 32'h7C7C_7C7C, 0, 1, "R1 nv last read");
    for (int i = 0; i < 5; i++)
      do_req(1, 14'h048, 32'(i), 0, 0, 10, "R11 nv write burst");
    drain();
    check(wear_count == 7, "R11 count saturated", wear_count, 7);
    wear_limit = 3'd7;
    @(negedge clk);
    check(wear_alarm == 1, "R11 alarm at max limit", wear_alarm, 1);
    do_req(0, 14'h048, 0, 32'd4, 0, 1, "R4 nv last burst value");
    drain();

    done = 1;
    check(sb.size() == 0, "scoreboard empty", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule